// File: doc/BRIEF.md
# Programmable Reload Down-Counter Timer

A 16-bit down-counter driven by a selectable clock prescaler and preset from a separately written reload register. Software programs the reload value as two bytes through a byte-wide register bus. It can copy that value into the live counter on demand, and it starts the timer by setting a run bit. The run bit sits in the same control byte as the mode and divider fields.

While running, the counter steps down once per prescaler period. When it reaches the end of its count, it sets a sticky status flag. In single-pass mode it then parks at zero and drops its own run bit. In continuous mode it reloads and keeps going, giving a periodic event. An interrupt line reports the status flag when the matching enable bit is set. Reading the status register acknowledges the flag.

Top module: `reload_timer`

## Requirements
- R1: After reset every readable register (address 0 control, 1 interrupt enable, 2 status, 3/4 reload low/high, 5/6 counter low/high) reads 0, address 7 reads 0, and `irq` is low.
- R2: Control byte layout: bit 0 run, bit 1 force-reload strobe, bit 2 continuous mode, bits 4:3 divider select. Bits 7:5 and bit 1 always read back as 0.
- R3: Divider select 00, 01, 10 and 11 give one counter step every 4, 16, 64 and 256 clocks. The first step lands exactly that many clocks after the write that sets run.
- R4: A control write that changes the divider select restarts the prescaler. The next step lands one full new period after that write.
- R5: A step taken while the counter is 1 or 0 is the end of count. In single-pass mode (bit 2 = 0) the counter becomes 0, the run bit clears itself, and counting stops.
- R6: In continuous mode the end of count loads the reload value and counting continues, so a reload value of N gives one end of count every N steps.
- R7: A control write with bit 1 set copies the reload register into the counter at that clock edge, whether or not run is set.
- R8: Writes to the reload bytes (address 3 low, 4 high) do not change the counter. They take effect only at the next force or continuous reload.
- R9: Status bit 0 sets at each end of count. A read of address 2 clears it, except that a new end of count in the same cycle keeps it set.
- R10: `irq` is high while status bit 0 and interrupt-enable bit 0 are both 1. Only interrupt-enable bit 0 is implemented. Bits 7:1 ignore writes and read 0.
- R11: While run is 0 the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (marks read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A corrupt prescaler count shows up at the counter readback as a step that comes early or late. The error is visible within one divider period, at most 256 clocks, of the write that started or retimed the timer. A wrong end-of-count decision shows in the control byte: the run bit stays set in single-pass mode. It also shows as a counter value other than 0 or the reload value on the cycle after the final step, and as a status flag that does not appear. A mis-latched reload or enable value becomes visible on the first force reload or interrupt check after it is written.

// File: rtl/rtmr_pkg.sv
// Shared definitions for the reload down-counter timer.
// Assumes a byte-wide register bus with a 3-bit address.
package rtmr_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 8;   // wide enough for a divide-by-256 period

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_IEN  = 3'd1,
        A_STAT = 3'd2,
        A_RLO  = 3'd3,
        A_RHI  = 3'd4,
        A_CLO  = 3'd5,
        A_CHI  = 3'd6
    } reg_addr_e;

    // Bit positions inside the control byte
    localparam int C_RUN   = 0;
    localparam int C_FORCE = 1;
    localparam int C_CONT  = 2;
    localparam int C_DIV_L = 3;
    localparam int C_DIV_H = 4;

    // Last prescaler count value for a divider select: 4, 16, 64 or 256 clocks
    function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
        logic [PRE_W:0] period;
        period = (PRE_W+1)'(4) << {sel, 1'b0};
        return PRE_W'(period - 1'b1);
    endfunction

endpackage

// File: rtl/rtmr_prescale.sv
// Prescaler: emits a one-clock tick every 4/16/64/256 clocks while run is set.
// Assumes clr is a single-cycle pulse raised by a control write that changes
// the divider select; the count restarts so the next tick is one full period out.
module rtmr_prescale
    import rtmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pc_q;
    logic [PRE_W-1:0] last;

    // Decode the terminal count for the active divider
    always_comb last = div_last(sel);

    // Tick on the terminal count unless the period is being restarted
    assign tick = run && !clr && (pc_q == last);

    // Free-running period counter, held at zero while stopped or restarting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (!run || clr || tick) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtmr_count.sv
// Down-counter with end-of-count detection and reload.
// Assumes tick only arrives while the timer runs. A forced load wins over a tick
// in the same cycle. End of count is a tick taken at a count of 1 or 0.
module rtmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             force_ld,
    input  logic             cont,
    input  logic [CNT_W-1:0] rld,
    output logic [CNT_W-1:0] cnt,
    output logic             eoc
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    // Final step: the counter is about to pass through zero
    assign at_end = (cnt_q <= CNT_W'(1));
    assign eoc    = tick && !force_ld && at_end;
    assign cnt    = cnt_q;

    // Load, reload, park at zero or step down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (force_ld) begin
            cnt_q <= rld;
        end else if (tick) begin
            if (at_end) begin
                cnt_q <= cont ? rld : '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtmr_regs.sv
// Register file for the timer: control, interrupt enable, status, reload.
// Assumes at most one access per cycle. Reading the status address clears it.
// The control run bit is also cleared by hardware at a single-pass end of count.
module rtmr_regs
    import rtmr_pkg::*;
#(
    parameter int         CNT_W    = 16,
    parameter logic [7:0] IEN_MASK = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              eoc,
    output logic [BUS_W-1:0]  rdata,
    output logic              run,
    output logic              cont,
    output logic [1:0]        sel,
    output logic              force_ld,
    output logic              presc_clr,
    output logic [CNT_W-1:0]  rld,
    output logic              flag,
    output logic              irq
);

    localparam int HI_W = CNT_W - BUS_W;

    logic             ctrl_wr, ien_wr, stat_rd;
    logic             run_q, cont_q, flag_q;
    logic [1:0]       sel_q;
    logic [BUS_W-1:0] ien_q;
    logic [CNT_W-1:0] rld_q;

    // Decode the accesses that have side effects
    assign ctrl_wr   = wr_en && (addr == A_CTRL);
    assign ien_wr    = wr_en && (addr == A_IEN);
    assign stat_rd   = rd_en && (addr == A_STAT);
    assign force_ld  = ctrl_wr && wdata[C_FORCE];
    assign presc_clr = ctrl_wr && (wdata[C_DIV_H:C_DIV_L] != sel_q);

    // Control fields; a software write overrides the hardware stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cont_q <= 1'b0;
            sel_q  <= 2'b00;
        end else if (ctrl_wr) begin
            run_q  <= wdata[C_RUN];
            cont_q <= wdata[C_CONT];
            sel_q  <= wdata[C_DIV_H:C_DIV_L];
        end else if (eoc && !cont_q) begin
            run_q  <= 1'b0;
        end
    end

    // Interrupt-enable bits: only positions present in IEN_MASK hold state
    for (genvar b = 0; b < BUS_W; b++) begin : g_ien
        if (IEN_MASK[b]) begin : g_on
            // Store one implemented enable bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ien_q[b] <= 1'b0;
                end else if (ien_wr) begin
                    ien_q[b] <= wdata[b];
                end
            end
        end else begin : g_off
            assign ien_q[b] = 1'b0;
        end
    end

    // Reload value, written one byte at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (wr_en && (addr == A_RLO)) begin
            rld_q[BUS_W-1:0] <= wdata;
        end else if (wr_en && (addr == A_RHI)) begin
            rld_q[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
        end
    end

    // Sticky end-of-count flag; a new event beats the read clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (eoc) begin
            flag_q <= 1'b1;
        end else if (stat_rd) begin
            flag_q <= 1'b0;
        end
    end

    // Read multiplexer; the force strobe and unused bits read as zero
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[C_RUN]             = run_q;
                rdata[C_CONT]            = cont_q;
                rdata[C_DIV_H:C_DIV_L]   = sel_q;
            end
            A_IEN:  rdata = ien_q;
            A_STAT: rdata[0] = flag_q;
            A_RLO:  rdata = rld_q[BUS_W-1:0];
            A_RHI:  rdata = BUS_W'(rld_q[CNT_W-1:BUS_W]);
            A_CLO:  rdata = cnt[BUS_W-1:0];
            A_CHI:  rdata = BUS_W'(cnt[CNT_W-1:BUS_W]);
            default: rdata = '0;
        endcase
    end

    assign run  = run_q;
    assign cont = cont_q;
    assign sel  = sel_q;
    assign rld  = rld_q;
    assign flag = flag_q;
    assign irq  = flag_q && ien_q[0];

endmodule

// File: rtl/reload_timer.sv
// Top of the reload down-counter timer: register file, prescaler and counter.
// Assumes a single clock domain and a synchronous active-low reset.
module reload_timer #(
    parameter int         CNT_W    = 16,
    parameter logic [7:0] IEN_MASK = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);

    logic             run_q, cont_q, force_ld, presc_clr, tick, eoc, flag_q;
    logic [1:0]       sel_q;
    logic [CNT_W-1:0] rld_q, cnt_q;

    rtmr_regs #(.CNT_W(CNT_W), .IEN_MASK(IEN_MASK)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .cnt       (cnt_q),
        .eoc       (eoc),
        .rdata     (rdata),
        .run       (run_q),
        .cont      (cont_q),
        .sel       (sel_q),
        .force_ld  (force_ld),
        .presc_clr (presc_clr),
        .rld       (rld_q),
        .flag      (flag_q),
        .irq       (irq)
    );

    rtmr_prescale presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .clr   (presc_clr),
        .sel   (sel_q),
        .tick  (tick)
    );

    rtmr_count #(.CNT_W(CNT_W)) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .force_ld (force_ld),
        .cont     (cont_q),
        .rld      (rld_q),
        .cnt      (cnt_q),
        .eoc      (eoc)
    );

endmodule

// File: rtl/rtmr_chk.sv
// Temporal checks on the timer, attached to reload_timer by bind.
module rtmr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [2:0]       addr,
    input logic [7:0]       wdata,
    input logic             run,
    input logic             cont,
    input logic             tick,
    input logic             eoc,
    input logic             flag,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] rld
);

    logic ctrl_wr, force_wr;
    assign ctrl_wr  = wr_en && (addr == 3'd0);
    assign force_wr = ctrl_wr && wdata[1];

    // R7
    force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> cnt == $past(rld));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt > CNT_W'(1) && !force_wr) |=> cnt == $past(cnt) - CNT_W'(1));

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && !cont && !ctrl_wr) |=> !run);

    // R11
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !force_wr) |=> $stable(cnt));

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> flag);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd2 && !eoc) |=> !flag);

endmodule

bind reload_timer rtmr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .run   (run_q),
    .cont  (cont_q),
    .tick  (tick),
    .eoc   (eoc),
    .flag  (flag_q),
    .cnt   (cnt_q),
    .rld   (rld_q)
);

// File: tb/reload_timer_tb_top.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares them.
module reload_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    reload_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Monitor: compare queued expectations mid low phase
    always @(negedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            exp_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {7'd0, irq} : rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        sb_q.push_back('{1'b0, e, tag});
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(negedge clk);
        addr = 3'd7;
        sb_q.push_back('{1'b1, {7'd0, e}, tag});
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(4);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 8'h00, "R1 reset read");
        irq_chk(1'b0, "R1 irq after reset");

        // R8 reload write leaves counter alone; R7 force copy
        wr(3'd3, 8'h05);
        wr(3'd4, 8'h00);
        rd_chk(3'd5, 8'h00, "R8 counter untouched by reload write");
        wr(3'd0, 8'h02);
        rd_chk(3'd5, 8'h05, "R7 force reload");
        rd_chk(3'd0, 8'h00, "R2 force bit reads 0");
        wr(3'd1, 8'h01);
        rd_chk(3'd1, 8'h01, "R10 enable bit stored");

        // R3 / R5: divide by 4, single pass from 5
        wr(3'd0, 8'h01);
        idle(3);
        rd_chk(3'd5, 8'h05, "R3 no step before 4 clocks");
        rd_chk(3'd5, 8'h04, "R3 step at 4 clocks");
        idle(15);
        rd_chk(3'd0, 8'h00, "R5 run cleared by hardware");
        rd_chk(3'd5, 8'h00, "R5 parked at zero");
        irq_chk(1'b1, "R10 irq with flag and enable");
        rd_chk(3'd2, 8'h01, "R9 status set");
        rd_chk(3'd2, 8'h00, "R9 status cleared by read");
        irq_chk(1'b0, "R10 irq drops after clear");
        idle(10);
        rd_chk(3'd5, 8'h00, "R11 holds while stopped");

        // R6: continuous, divide by 16, reload 3
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h0F);
        idle(47);
        rd_chk(3'd2, 8'h00, "R6 no event before period");
        irq_chk(1'b0, "R10 irq gated by enable");
        rd_chk(3'd2, 8'h01, "R9 set wins over read clear");
        rd_chk(3'd5, 8'h03, "R6 reloaded");
        idle(44);
        rd_chk(3'd5, 8'h01, "R6 counting down again");
        rd_chk(3'd2, 8'h01, "R6 periodic event");
        rd_chk(3'd5, 8'h03, "R6 second reload");

        // R3 / R4: divide by 64, then switch to 256 mid run
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h10);
        wr(3'd0, 8'h17);
        idle(63);
        rd_chk(3'd5, 8'h10, "R3 no step before 64 clocks");
        rd_chk(3'd5, 8'h0F, "R3 step at 64 clocks");
        wr(3'd0, 8'h1D);
        idle(255);
        rd_chk(3'd5, 8'h0F, "R4 no step before new period");
        rd_chk(3'd5, 8'h0E, "R4 step one full new period after change");

        // R10 unused enable bits, R2 upper control bits, R8 pending reload
        wr(3'd1, 8'hFF);
        rd_chk(3'd1, 8'h01, "R10 unused enable bits read 0");
        wr(3'd0, 8'hF8);
        rd_chk(3'd0, 8'h18, "R2 upper control bits read 0");
        wr(3'd3, 8'h40);
        wr(3'd4, 8'h01);
        rd_chk(3'd6, 8'h00, "R8 high byte not yet in counter");
        rd_chk(3'd4, 8'h01, "R8 reload high readback");
        rd_chk(3'd3, 8'h40, "R8 reload low readback");
        wr(3'd0, 8'h1A);
        rd_chk(3'd6, 8'h01, "R7 force loads high byte");
        rd_chk(3'd5, 8'h40, "R7 force loads low byte");
        idle(300);
        rd_chk(3'd5, 8'h40, "R11 no count without run");

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule